// File: doc/BRIEF.md
# Frequency-Difference Sign Detector

This block decides which of two oscillators is running faster when their frequencies differ by very little. It receives two inputs. One is a level that is high while oscillator 1 is in the positive half of its cycle. The other is a single-cycle pulse stream taken from oscillator 2. The pulse stream goes to a direct coincidence channel (A) and, through a fixed delay of `DELAY_CYCLES` clocks, to a delayed coincidence channel (B). As the two oscillators drift past each other once per beat period, one of the two coincidence trains starts before the other. The order in which they start gives the sign of the frequency difference.

A three-state arming machine is at the centre of the block. In `ST_IDLE` both channels may arm, and neither channel can write the result. The first channel to produce a coincidence moves the machine to `ST_A_ARMED` or `ST_B_ARMED`. In that state the other channel can no longer arm, and its pulses drive the result register instead. The armed state stays alive while the arming train continues. It falls back to `ST_IDLE` after `HOLD_CYCLES` clocks with no pulse from the arming channel. The transitions are:

- IDLE→A_ARMED on a channel A hit, which takes priority.
- IDLE→B_ARMED on a channel B hit alone.
- A_ARMED→IDLE and B_ARMED→IDLE on hold-off expiry.
- A_ARMED→A_ARMED and B_ARMED→B_ARMED otherwise. These are self-loops, and a hit from the arming channel reloads the hold-off.

The result is a registered flag `f1_slower` with a one-cycle strobe `flag_strobe`. A supervising tuning loop can read them.

Top module: `fdiff_sign_detect`

## Requirements
- R1: Channel A registers a hit on the clock edge after an edge at which `osc2_pulse` and `osc1_level` are both 1.
- R2: Channel B registers a hit when a copy of `osc2_pulse` delayed by exactly `DELAY_CYCLES` clocks coincides with `osc1_level` = 1. The level is taken at the delayed instant, not at the original pulse.
- R3: In `ST_IDLE` no hit changes the flag. A train from one channel that starts or ends while the other channel is silent leaves the flag unchanged.
- R4: A channel B hit while in `ST_A_ARMED` sets `f1_slower` to 1, meaning f1 < f2.
- R5: A channel A hit while in `ST_B_ARMED` clears `f1_slower` to 0, meaning f1 > f2.
- R6: Each hit from the arming channel restarts the hold-off. The armed state covers exactly `HOLD_CYCLES` consumed clocks after the last arming hit. A cross-channel hit on the last of those clocks still writes the flag. A hit one clock later meets `ST_IDLE` and arms instead.
- R7: When the first hits of A and B arrive on the same clock in `ST_IDLE`, the machine enters `ST_A_ARMED`.
- R8: A write that would leave `f1_slower` at its present value is ignored: no strobe and no change.
- R9: A synchronous active-high `rst` clears `f1_slower`, `flag_strobe`, the arming state and the delay line.
- R10: `flag_strobe` is high for exactly one cycle, on the same cycle that `f1_slower` takes a new value. That is one clock after the edge at which the state machine consumes the cross-channel hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous reset, active high |
| osc1_level | input | 1 | High during oscillator 1 positive half-wave |
| osc2_pulse | input | 1 | One-cycle pulses derived from oscillator 2 |
| f1_slower | output | 1 | 1 when f1 < f2, 0 when f1 > f2 |
| flag_strobe | output | 1 | One-cycle mark of each flag change |

## Verification
Two events can coincide on the same clock. The first is the end of an armed window through hold-off expiry. The second is an arriving cross-channel hit. The bench places a delayed-channel hit on the last armed clock and expects a write. It then places the mirror case one clock later and expects no write, only a new arming. The bench also lines up a direct hit and a delayed hit on the same idle clock. A later delayed hit that produces a write is the evidence that channel A won.

// File: rtl/fdiff_pkg.sv
package fdiff_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_A_ARMED = 2'd1,
        ST_B_ARMED = 2'd2
    } arm_state_t;

    // Flag values written by each cross-channel path
    localparam logic SIGN_F1_SLOWER = 1'b1;
    localparam logic SIGN_F1_FASTER = 1'b0;

endpackage

// File: rtl/fdiff_pulse_delay.sv
module fdiff_pulse_delay #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    output logic pulse_out
);
    logic [DEPTH-1:0] chain_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= pulse_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[DEPTH-2:0], pulse_in};
            end
        end
    endgenerate

    assign pulse_out = chain_q[DEPTH-1];

    // R9: after a reset edge the chain is empty
    a_r9_chain_clear: assert property (@(posedge clk) rst |=> (chain_q == '0));

endmodule

// File: rtl/fdiff_coincide.sv
module fdiff_coincide (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic pulse,
    output logic hit
);
    always_ff @(posedge clk) begin
        if (rst) hit <= 1'b0;
        else     hit <= level & pulse;
    end
endmodule

// File: rtl/fdiff_arm_fsm.sv
module fdiff_arm_fsm
    import fdiff_pkg::*;
#(
    parameter int HOLD_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic hit_a,
    input  logic hit_b,
    output logic flag,
    output logic strobe
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] QUIET_LAST = CW'(HOLD_CYCLES - 1);

    arm_state_t     state_q, state_d;
    logic [CW-1:0]  quiet_q, quiet_d;
    logic           wr_en;
    logic           wr_val;

    // Next-state and write decision
    always_comb begin
        state_d = state_q;
        quiet_d = quiet_q;
        wr_en   = 1'b0;
        wr_val  = SIGN_F1_FASTER;
        unique case (state_q)
            ST_IDLE: begin
                if (hit_a) begin
                    state_d = ST_A_ARMED;
                    quiet_d = '0;
                end else if (hit_b) begin
                    state_d = ST_B_ARMED;
                    quiet_d = '0;
                end
            end
            ST_A_ARMED: begin
                if (hit_b) begin
                    wr_en  = 1'b1;
                    wr_val = SIGN_F1_SLOWER;
                end
                if (hit_a) begin
                    quiet_d = '0;
                end else if (quiet_q == QUIET_LAST) begin
                    state_d = ST_IDLE;
                    quiet_d = '0;
                end else begin
                    quiet_d = quiet_q + 1'b1;
                end
            end
            ST_B_ARMED: begin
                if (hit_a) begin
                    wr_en  = 1'b1;
                    wr_val = SIGN_F1_FASTER;
                end
                if (hit_b) begin
                    quiet_d = '0;
                end else if (quiet_q == QUIET_LAST) begin
                    state_d = ST_IDLE;
                    quiet_d = '0;
                end else begin
                    quiet_d = quiet_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                quiet_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            quiet_q <= '0;
        end else begin
            state_q <= state_d;
            quiet_q <= quiet_d;
        end
    end

    // Output register: only a changing write lands
    always_ff @(posedge clk) begin
        if (rst) begin
            flag   <= 1'b0;
            strobe <= 1'b0;
        end else if (wr_en && (wr_val != flag)) begin
            flag   <= wr_val;
            strobe <= 1'b1;
        end else begin
            strobe <= 1'b0;
        end
    end

    // R3: a clock consumed in idle never produces a strobe
    a_r3_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> !strobe);

    // R7: simultaneous first hits arm channel A
    a_r7_a_wins: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && hit_a && hit_b) |=> (state_q == ST_A_ARMED));

    // R6: hold-off counter stays inside its window
    a_r6_quiet_bound: assert property (@(posedge clk) disable iff (rst)
        quiet_q < CW'(HOLD_CYCLES));

    // R6: an arming hit keeps the armed state on the next clock
    a_r6_reload_keeps: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_A_ARMED && hit_a) |=> (state_q == ST_A_ARMED));

endmodule

// File: rtl/fdiff_sign_detect.sv
module fdiff_sign_detect #(
    parameter int DELAY_CYCLES = 4,
    parameter int HOLD_CYCLES  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic osc1_level,
    input  logic osc2_pulse,
    output logic f1_slower,
    output logic flag_strobe
);
    logic dly_pulse;
    logic hit_a;
    logic hit_b;

    fdiff_pulse_delay #(.DEPTH(DELAY_CYCLES)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (osc2_pulse),
        .pulse_out(dly_pulse)
    );

    fdiff_coincide u_chan_a (
        .clk  (clk),
        .rst  (rst),
        .level(osc1_level),
        .pulse(osc2_pulse),
        .hit  (hit_a)
    );

    fdiff_coincide u_chan_b (
        .clk  (clk),
        .rst  (rst),
        .level(osc1_level),
        .pulse(dly_pulse),
        .hit  (hit_b)
    );

    fdiff_arm_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .hit_a (hit_a),
        .hit_b (hit_b),
        .flag  (f1_slower),
        .strobe(flag_strobe)
    );

    // R1: direct coincidence becomes a channel A hit one edge later
    a_r1_chan_a: assert property (@(posedge clk) disable iff (rst)
        (osc1_level && osc2_pulse) |=> hit_a);

    // R2: delayed coincidence becomes a channel B hit one edge later
    a_r2_chan_b: assert property (@(posedge clk) disable iff (rst)
        (osc1_level && dly_pulse) |=> hit_b);

    // R10: a strobe always comes with a new flag value
    a_r10_strobe_change: assert property (@(posedge clk) disable iff (rst)
        flag_strobe |-> (f1_slower != $past(f1_slower)));

    // R8: without a strobe the flag holds
    a_r8_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !flag_strobe |-> $stable(f1_slower));

endmodule

// File: tb/test_fdiff_sign_detect.sv
module test_fdiff_sign_detect;
    localparam int D = 4;
    localparam int H = 10;
    localparam int P = D + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc1_level = 1'b0;
    logic osc2_pulse = 1'b0;
    logic f1_slower;
    logic flag_strobe;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    fdiff_sign_detect #(.DELAY_CYCLES(D), .HOLD_CYCLES(H)) i_fdiff_sign_detect (
        .clk        (clk),
        .rst        (rst),
        .osc1_level (osc1_level),
        .osc2_pulse (osc2_pulse),
        .f1_slower  (f1_slower),
        .flag_strobe(flag_strobe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Bit i of lv/pl is applied on step i; outputs sampled after that step's edge
    task automatic play(input logic [63:0] lv, input logic [63:0] pl, input int n,
                        output int cnt, output int first);
        cnt   = 0;
        first = -1;
        for (int i = 0; i < n; i++) begin
            osc1_level = lv[i];
            osc2_pulse = pl[i];
            @(negedge clk);
            if (flag_strobe) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        osc1_level = 1'b0;
        osc2_pulse = 1'b0;
    endtask

    task automatic idle(input int n);
        osc1_level = 1'b0;
        osc2_pulse = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check(f1_slower == 1'b0, "R9", "flag after reset", f1_slower, 0);
        check(flag_strobe == 1'b0, "R9", "strobe after reset", flag_strobe, 0);
    endtask

    task automatic t_a_first;
        logic [63:0] lv = '0, pl = '0;
        int cnt, first;
        for (int i = 0; i <= D + 2; i++) lv[i] = 1'b1;
        pl[0] = 1'b1;
        play(lv, pl, D + 4, cnt, first);
        check(f1_slower == 1'b1, "R4", "flag after A-first", f1_slower, 1);
        check(first == D + 1, "R10", "strobe step", first, D + 1);
        check(cnt == 1, "R10", "strobe count", cnt, 1);
        check(first == D + 1, "R1", "direct hit arms A", first, D + 1);
    endtask

    task automatic t_same_state;
        logic [63:0] lv = '0, pl = '0;
        int cnt, first;
        for (int i = 0; i <= D + 2; i++) lv[i] = 1'b1;
        pl[0] = 1'b1;
        play(lv, pl, D + 4, cnt, first);
        check(cnt == 0, "R8", "strobe on repeat", cnt, 0);
        check(f1_slower == 1'b1, "R8", "flag on repeat", f1_slower, 1);
    endtask

    task automatic t_b_first;
        logic [63:0] lv = '0, pl = '0;
        int cnt, first;
        pl[0] = 1'b1; lv[D] = 1'b1;
        pl[D + 2] = 1'b1; lv[D + 2] = 1'b1;
        play(lv, pl, 2 * D + 4, cnt, first);
        check(f1_slower == 1'b0, "R5", "flag after B-first", f1_slower, 0);
        check(first == D + 3, "R2", "delayed hit arms B", first, D + 3);
        check(cnt == 1, "R10", "strobe count B-first", cnt, 1);
    endtask

    task automatic t_lone_trains;
        logic [63:0] lv = '0, pl = '0;
        int cnt, first;
        pl[0] = 1'b1; lv[D] = 1'b1;          // B train alone
        pl[20] = 1'b1; lv[20] = 1'b1;        // A train alone, after B ended
        play(lv, pl, 35, cnt, first);
        check(cnt == 0, "R3", "strobe on lone trains", cnt, 0);
        check(f1_slower == 1'b0, "R3", "flag on lone trains", f1_slower, 0);
    endtask

    task automatic t_last_armed;
        logic [63:0] lv = '0, pl = '0;
        int cnt, first;
        pl[0] = 1'b1; lv[0] = 1'b1;
        pl[H - D] = 1'b1; lv[H] = 1'b1;
        play(lv, pl, H + 4, cnt, first);
        check(f1_slower == 1'b1, "R6", "write on last armed clock", f1_slower, 1);
        check(first == H + 1, "R6", "strobe step last armed", first, H + 1);
    endtask

    task automatic t_one_past;
        logic [63:0] lv = '0, pl = '0;
        int cnt, first;
        pl[0] = 1'b1; lv[D] = 1'b1;
        pl[D + 1 + H] = 1'b1; lv[D + 1 + H] = 1'b1;
        play(lv, pl, H + D + 8, cnt, first);
        check(cnt == 0, "R6", "strobe one past window", cnt, 0);
        check(f1_slower == 1'b1, "R6", "flag one past window", f1_slower, 1);
    endtask

    task automatic t_reload;
        logic [63:0] lv = '0, pl = '0;
        int cnt, first;
        for (int k = 0; k < 3; k++) begin
            pl[k * P] = 1'b1;
            lv[k * P + D] = 1'b1;
        end
        pl[2 * P + D + H - 2] = 1'b1;
        lv[2 * P + D + H - 2] = 1'b1;
        play(lv, pl, 2 * P + D + H + 2, cnt, first);
        check(f1_slower == 1'b0, "R6", "flag after reloaded train", f1_slower, 0);
        check(first == 2 * P + D + H - 1, "R6", "strobe step reload", first, 2 * P + D + H - 1);
    endtask

    task automatic t_priority;
        logic [63:0] lv = '0, pl = '0;
        int cnt, first;
        pl[0] = 1'b1;
        pl[D] = 1'b1; lv[D] = 1'b1;
        pl[D + 2] = 1'b1; lv[2 * D + 2] = 1'b1;
        play(lv, pl, 2 * D + 6, cnt, first);
        check(f1_slower == 1'b1, "R7", "flag after tie", f1_slower, 1);
        check(first == 2 * D + 3, "R7", "strobe step after tie", first, 2 * D + 3);
    endtask

    task automatic t_mid_reset;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(f1_slower == 1'b0, "R9", "flag cleared by reset", f1_slower, 0);
        check(flag_strobe == 1'b0, "R9", "strobe cleared by reset", flag_strobe, 0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_a_first();     idle(25);
        t_same_state();  idle(25);
        t_b_first();     idle(25);
        t_lone_trains(); idle(25);
        t_last_armed();  idle(25);
        t_one_past();    idle(25);
        t_reload();      idle(25);
        t_priority();    idle(25);
        t_mid_reset();
        done = 1;
    end

    initial begin
        int waited = 0;
        while (!done && waited < 200000) begin
            @(posedge clk);
            waited++;
        end
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", waited, 0);
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule